// File: doc/BRIEF.md
# Predicated Vector Exponent Extractor

This block takes a vector of packed IEEE floating-point elements and, for every element, produces the element's unbiased base-2 exponent as a signed integer of the same width as the element. The elements can be half, single or double precision, chosen per operation. The block writes the results into a destination vector under a per-lane predicate. Lanes whose predicate bit is clear keep the value from the old destination vector that is supplied with the operation.

Zero, infinity and NaN have no finite exponent, so each gets a fixed saturated code. Subnormal inputs are normalised by locating the highest set bit of the fraction, which gives the true exponent of the value. One operation is accepted per `in_valid` cycle. Its result appears in a register on the next cycle, together with a one-cycle `out_valid` pulse. A reserved size code is reported as illegal, and the old destination is passed through unchanged.

Top module: `vec_logb_unit`

## Requirements
- R1: For a normal element, the lane result is the biased exponent field minus the bias. The exponent field sits at bits 14:10 for half (bias 15), at bits 30:23 for single (bias 127) and at bits 62:52 for double (bias 1023). The sign bit is the top bit of the element.
- R2: An infinite element of either sign gives the most positive signed integer of the element width (0x7FFF, 0x7FFFFFFF or 0x7FFF_FFFF_FFFF_FFFF).
- R3: A zero of either sign, or any NaN (quiet or signalling), gives the most negative signed integer of the element width (0x8000 and so on).
- R4: A subnormal element with fraction width F, bias B and highest set fraction bit p gives p + 1 − B − F. For half, fraction 0x200 gives −15 (0xFFF1) and fraction 0x001 gives −24 (0xFFE8).
- R5: The sign bit does not affect the result. Elements that differ only in the sign bit give the same lane result.
- R6: `esize` 01 selects 16-bit lanes, 10 selects 32-bit lanes and 11 selects 64-bit lanes. Lane i occupies bits [i*W +: W]. The lane is governed by predicate bit i*W/8, which is the bit for the lane's lowest byte.
- R7: A lane whose governing predicate bit is 0 takes its value from `old_dst` unchanged. Predicate bits that do not govern any lane have no effect.
- R8: `esize` 00 is reserved. The operation completes with `out_illegal` set and `dst_vec` equal to `old_dst`. A legal code completes with `out_illegal` clear.
- R9: After reset, `out_valid` and `out_illegal` are 0 and `dst_vec` is 0. Each accepted `in_valid` cycle produces exactly one `out_valid` cycle on the next clock, with the result in `dst_vec`. When `in_valid` is low, `dst_vec` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accepts an operation this cycle |
| esize | input | 2 | Element size code (01 half, 10 single, 11 double, 00 reserved) |
| src_vec | input | VLEN | Source floating-point elements |
| old_dst | input | VLEN | Previous destination, merged into inactive lanes |
| pred | input | VLEN/8 | Predicate, one bit per byte |
| out_valid | output | 1 | One-cycle pulse marking a completed operation |
| out_illegal | output | 1 | Completed operation used the reserved size code |
| dst_vec | output | VLEN | Registered result vector |

## Verification
The bench builds the block with the default VLEN of 128. This gives eight half, four single and two double lanes, with sixteen predicate bits. Both the predicate bits that govern lanes and the bits that govern none can therefore be driven. With this width every special class can be broadcast across several lanes of each size in one operation. Random predicates then mix active and merged lanes within a single vector, and there are enough lanes to show that the lowest-byte bit alone decides a lane.

// File: rtl/logb_pkg.sv
package logb_pkg;

  typedef enum logic [1:0] {
    SZ_RSVD = 2'b00,
    SZ_HALF = 2'b01,
    SZ_SNGL = 2'b10,
    SZ_DBLE = 2'b11
  } elem_size_e;

  // Exponent field width for a given element width.
  function automatic int exp_width(input int ew);
    case (ew)
      16:      return 5;
      32:      return 8;
      default: return 11;
    endcase
  endfunction

  // Leading zeros of the low n bits of v (n when all are zero).
  function automatic int lead_zeros(input logic [63:0] v, input int n);
    int cnt;
    cnt = n;
    for (int i = 0; i < 64; i++) begin
      if (i < n && v[i]) cnt = n - 1 - i;
    end
    return cnt;
  endfunction

endpackage

// File: rtl/logb_lane.sv
module logb_lane #(
  parameter int EW = 16
) (
  input  logic [EW-1:0] elem,
  output logic [EW-1:0] res
);
  import logb_pkg::*;

  localparam int EXP_W  = exp_width(EW);
  localparam int FRAC_W = EW - 1 - EXP_W;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_zero, exp_ones, frac_nz;
  logic              is_zero, is_sub, is_inf, is_nan;
  int                lz;
  longint            norm_val, sub_val;

  assign exp_f    = elem[EW-2 -: EXP_W];
  assign frac_f   = elem[FRAC_W-1:0];
  assign exp_zero = (exp_f == '0);
  assign exp_ones = (exp_f == '1);
  assign frac_nz  = (frac_f != '0);

  assign is_zero = exp_zero && !frac_nz;
  assign is_sub  = exp_zero &&  frac_nz;
  assign is_inf  = exp_ones && !frac_nz;
  assign is_nan  = exp_ones &&  frac_nz;

  always_comb begin
    lz       = lead_zeros({{(64-FRAC_W){1'b0}}, frac_f}, FRAC_W);
    norm_val = longint'({{(64-EXP_W){1'b0}}, exp_f}) - longint'(BIAS);
    sub_val  = -longint'(BIAS) - longint'(lz);
  end

  always_comb begin
    if (is_inf)
      res = {1'b0, {(EW-1){1'b1}}};
    else if (is_nan || is_zero)
      res = {1'b1, {(EW-1){1'b0}}};
    else if (is_sub)
      res = sub_val[EW-1:0];
    else
      res = norm_val[EW-1:0];
  end

  // Classes are mutually exclusive (R2, R3, R4).
  always_comb begin
    a_r3_class_exclusive: assert ($onehot0({is_zero, is_sub, is_inf, is_nan}))
      else $error("lane classes overlap");
  end

  // A subnormal exponent always lies below the smallest normal exponent.
  always_comb begin
    a_r4_sub_range: assert (!is_sub ||
      (sub_val <= -longint'(BIAS) && sub_val >= -longint'(BIAS) - longint'(FRAC_W) + 1))
      else $error("subnormal exponent out of range");
  end

endmodule

// File: rtl/logb_slice.sv
module logb_slice #(
  parameter int VLEN = 128,
  parameter int EW   = 16
) (
  input  logic [VLEN-1:0]   src,
  input  logic [VLEN-1:0]   old,
  input  logic [VLEN/8-1:0] pred,
  output logic [VLEN-1:0]   merged
);
  localparam int NLANE = VLEN / EW;
  localparam int BPL   = EW / 8;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    logic [EW-1:0] lane_res;
    logic          lane_on;

    assign lane_on = pred[i*BPL];

    logb_lane #(.EW(EW)) u_lane (
      .elem (src[i*EW +: EW]),
      .res  (lane_res)
    );

    assign merged[i*EW +: EW] = lane_on ? lane_res : old[i*EW +: EW];

    // Inactive lanes carry the old destination (R7).
    always_comb begin
      a_r7_inactive_keeps: assert (lane_on || merged[i*EW +: EW] == old[i*EW +: EW])
        else $error("inactive lane modified");
    end
  end

endmodule

// File: rtl/vec_logb_unit.sv
module vec_logb_unit #(
  parameter int VLEN = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        esize,
  input  logic [VLEN-1:0]   src_vec,
  input  logic [VLEN-1:0]   old_dst,
  input  logic [VLEN/8-1:0] pred,
  output logic              out_valid,
  output logic              out_illegal,
  output logic [VLEN-1:0]   dst_vec
);
  import logb_pkg::*;

  localparam int NSZ = 3;

  logic [VLEN-1:0] slice_out [NSZ];
  logic [VLEN-1:0] next_dst;
  logic            size_bad;

  for (genvar g = 0; g < NSZ; g++) begin : g_size
    localparam int EW = 16 << g;
    logb_slice #(.VLEN(VLEN), .EW(EW)) u_slice (
      .src    (src_vec),
      .old    (old_dst),
      .pred   (pred),
      .merged (slice_out[g])
    );
  end

  assign size_bad = (elem_size_e'(esize) == SZ_RSVD);

  always_comb begin
    case (elem_size_e'(esize))
      SZ_HALF: next_dst = slice_out[0];
      SZ_SNGL: next_dst = slice_out[1];
      SZ_DBLE: next_dst = slice_out[2];
      default: next_dst = old_dst;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      dst_vec     <= '0;
    end else begin
      out_valid   <= in_valid;
      out_illegal <= in_valid && size_bad;
      if (in_valid) dst_vec <= next_dst;
    end
  end

  a_r9_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r9_dst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(dst_vec));

  a_r8_illegal_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && esize == 2'b00) |=> (out_illegal && dst_vec == $past(old_dst)));

  a_r8_legal_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && esize != 2'b00) |=> !out_illegal);

endmodule

// File: tb/vec_logb_unit_tb_top.sv
module vec_logb_unit_tb_top;
  localparam int VLEN = 128;
  localparam int PW   = VLEN / 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [1:0]      esize = 2'b00;
  logic [VLEN-1:0] src_vec = '0;
  logic [VLEN-1:0] old_dst = '0;
  logic [PW-1:0]   pred = '0;
  logic            out_valid, out_illegal;
  logic [VLEN-1:0] dst_vec;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  vec_logb_unit #(.VLEN(VLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .esize(esize),
    .src_vec(src_vec), .old_dst(old_dst), .pred(pred),
    .out_valid(out_valid), .out_illegal(out_illegal), .dst_vec(dst_vec)
  );

  // ---------------- reference model ----------------
  function automatic logic [63:0] wmask(input int ew);
    return (ew == 64) ? '1 : ((64'd1 << ew) - 64'd1);
  endfunction

  function automatic logic [63:0] model_elem(input logic [63:0] x, input int ew);
    int ebits, fbits, bias, p;
    logic [63:0] e, f;
    longint r;
    ebits = (ew == 16) ? 5 : (ew == 32) ? 8 : 11;
    fbits = ew - 1 - ebits;
    bias  = (1 << (ebits - 1)) - 1;
    e = (x >> fbits) & ((64'd1 << ebits) - 64'd1);
    f = x & ((64'd1 << fbits) - 64'd1);
    if (e == ((64'd1 << ebits) - 64'd1)) begin
      if (f == 0) return (64'd1 << (ew - 1)) - 64'd1;
      return 64'd1 << (ew - 1);
    end
    if (e == 0) begin
      if (f == 0) return 64'd1 << (ew - 1);
      p = 0;
      for (int k = 0; k < 64; k++) if (f[k]) p = k;
      r = longint'(p) + 1 - longint'(bias) - longint'(fbits);
    end else begin
      r = longint'(e) - longint'(bias);
    end
    return 64'(r) & wmask(ew);
  endfunction

  function automatic int ew_of(input logic [1:0] c);
    return (c == 2'b01) ? 16 : (c == 2'b10) ? 32 : 64;
  endfunction

  function automatic logic [VLEN-1:0] model_vec(input logic [1:0] c,
      input logic [VLEN-1:0] s, input logic [VLEN-1:0] o, input logic [PW-1:0] pr);
    logic [VLEN-1:0] r;
    logic [63:0] lane;
    int ew;
    if (c == 2'b00) return o;
    ew = ew_of(c);
    r = '0;
    for (int i = 0; i < VLEN / ew; i++) begin
      if (pr[i * ew / 8]) lane = model_elem(64'(s >> (i * ew)) & wmask(ew), ew);
      else                lane = 64'(o >> (i * ew)) & wmask(ew);
      r = r | (VLEN'(lane) << (i * ew));
    end
    return r;
  endfunction

  function automatic logic [VLEN-1:0] bcast(input logic [63:0] v, input int ew);
    logic [VLEN-1:0] r;
    r = '0;
    for (int i = 0; i < VLEN / ew; i++) r = r | (VLEN'(v & wmask(ew)) << (i * ew));
    return r;
  endfunction

  function automatic logic [VLEN-1:0] rnd_vec();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // ---------------- checking ----------------
  task automatic check(input bit ok, input string tag,
                       input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Drives one operation; returns at the negedge where its result is visible.
  task automatic issue(input logic [1:0] c, input logic [VLEN-1:0] s,
                       input logic [VLEN-1:0] o, input logic [PW-1:0] pr);
    esize = c; src_vec = s; old_dst = o; pred = pr; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_and_check(input logic [1:0] c, input logic [VLEN-1:0] s,
      input logic [VLEN-1:0] o, input logic [PW-1:0] pr, input string tag);
    logic [VLEN-1:0] exp;
    exp = model_vec(c, s, o, pr);
    issue(c, s, o, pr);
    check(out_valid == 1'b1, {tag, " R9 valid"}, VLEN'(out_valid), VLEN'(1));
    check(out_illegal == (c == 2'b00), {tag, " R8 illegal flag"},
          VLEN'(out_illegal), VLEN'(c == 2'b00));
    check(dst_vec == exp, tag, dst_vec, exp);
    @(negedge clk);
    check(out_valid == 1'b0, {tag, " R9 single pulse"}, VLEN'(out_valid), VLEN'(0));
    check(dst_vec == exp, {tag, " R9 hold"}, dst_vec, exp);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check(out_valid == 1'b0 && out_illegal == 1'b0, "R9 reset flags",
          VLEN'({out_valid, out_illegal}), VLEN'(0));
    check(dst_vec == '0, "R9 reset dst", dst_vec, '0);
  endtask

  task automatic t_known_values();
    logic [VLEN-1:0] o;
    o = rnd_vec();
    issue(2'b01, bcast(64'h0001, 16), o, '1);
    check(dst_vec[15:0] == 16'hFFE8, "R4 half min subnormal -24", VLEN'(dst_vec[15:0]), VLEN'(16'hFFE8));
    @(negedge clk);
    issue(2'b01, bcast(64'h0200, 16), o, '1);
    check(dst_vec[15:0] == 16'hFFF1, "R4 half max-bit subnormal -15", VLEN'(dst_vec[15:0]), VLEN'(16'hFFF1));
    @(negedge clk);
    issue(2'b10, bcast(64'h3F80_0000, 32), o, '1);
    check(dst_vec[31:0] == 32'h0, "R1 single 1.0 gives 0", VLEN'(dst_vec[31:0]), VLEN'(0));
    @(negedge clk);
    issue(2'b11, bcast(64'h7FEF_FFFF_FFFF_FFFF, 64), o, '1);
    check(dst_vec[63:0] == 64'd1023, "R1 double max normal 1023", VLEN'(dst_vec[63:0]), VLEN'(1023));
    @(negedge clk);
    issue(2'b11, bcast(64'hFFF0_0000_0000_0000, 64), o, '1);
    check(dst_vec[63:0] == 64'h7FFF_FFFF_FFFF_FFFF, "R2 double -inf", VLEN'(dst_vec[63:0]), VLEN'(64'h7FFF_FFFF_FFFF_FFFF));
    @(negedge clk);
    issue(2'b10, bcast(64'h8000_0000, 32), o, '1);
    check(dst_vec[31:0] == 32'h8000_0000, "R3 single -0", VLEN'(dst_vec[31:0]), VLEN'(32'h8000_0000));
    @(negedge clk);
  endtask

  task automatic t_specials(input logic [1:0] c);
    int ew, eb, fb;
    logic [63:0] sgn, eall, fall, v;
    string tg;
    ew = ew_of(c);
    eb = (ew == 16) ? 5 : (ew == 32) ? 8 : 11;
    fb = ew - 1 - eb;
    sgn  = 64'd1 << (ew - 1);
    fall = (64'd1 << fb) - 64'd1;
    eall = ((64'd1 << eb) - 64'd1) << fb;
    for (int k = 0; k < 10; k++) begin
      case (k)
        0: begin v = 64'd0;                  tg = "R3 +zero"; end
        1: begin v = sgn;                    tg = "R3 -zero"; end
        2: begin v = eall;                   tg = "R2 +inf"; end
        3: begin v = eall | sgn;             tg = "R2 -inf"; end
        4: begin v = eall | (64'd1 << (fb-1)); tg = "R3 quiet NaN"; end
        5: begin v = eall | 64'd1;           tg = "R3 signalling NaN"; end
        6: begin v = 64'd1;                  tg = "R4 min subnormal"; end
        7: begin v = fall;                   tg = "R4 max subnormal"; end
        8: begin v = 64'd1 << fb;            tg = "R1 min normal"; end
        default: begin v = (eall - (64'd1 << fb)) | fall; tg = "R1 max normal"; end
      endcase
      run_and_check(c, bcast(v, ew), rnd_vec(), '1, $sformatf("%s ew=%0d R6", tg, ew));
    end
  endtask

  task automatic t_sign(input logic [1:0] c);
    int ew;
    logic [VLEN-1:0] s, sn, m, o, r_pos;
    ew = ew_of(c);
    m = bcast(64'd1 << (ew - 1), ew);
    o = rnd_vec();
    for (int k = 0; k < 4; k++) begin
      s  = rnd_vec() & ~m;
      sn = s | m;
      issue(c, s, o, '1);
      r_pos = dst_vec;
      @(negedge clk);
      issue(c, sn, o, '1);
      check(dst_vec == r_pos, $sformatf("R5 sign ignored ew=%0d", ew), dst_vec, r_pos);
      @(negedge clk);
    end
  endtask

  task automatic t_predicates(input logic [1:0] c);
    for (int k = 0; k < 6; k++)
      run_and_check(c, rnd_vec(), rnd_vec(), PW'($urandom),
                    $sformatf("R6 R7 random predicate ew=%0d", ew_of(c)));
    // Only the non-governing predicate bits set: every lane keeps old (R7).
    if (c != 2'b01) begin
      logic [PW-1:0] pr;
      pr = '1;
      for (int i = 0; i < PW; i += ew_of(c) / 8) pr[i] = 1'b0;
      run_and_check(c, rnd_vec(), rnd_vec(), pr,
                    $sformatf("R7 non-governing bits ew=%0d", ew_of(c)));
    end
  endtask

  task automatic t_illegal();
    run_and_check(2'b00, rnd_vec(), rnd_vec(), '1, "R8 reserved size");
    run_and_check(2'b01, rnd_vec(), rnd_vec(), '1, "R8 legal after reserved");
  endtask

  task automatic t_back_to_back();
    logic [VLEN-1:0] sa, sb, o, ea, eb;
    sa = rnd_vec(); sb = rnd_vec(); o = rnd_vec();
    ea = model_vec(2'b10, sa, o, '1);
    eb = model_vec(2'b11, sb, o, 16'h00FF);
    esize = 2'b10; src_vec = sa; old_dst = o; pred = '1; in_valid = 1'b1;
    @(negedge clk);
    check(out_valid && dst_vec == ea, "R9 back-to-back first", dst_vec, ea);
    esize = 2'b11; src_vec = sb; pred = 16'h00FF;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && dst_vec == eb, "R9 back-to-back second", dst_vec, eb);
    @(negedge clk);
    check(!out_valid, "R9 back-to-back ends", VLEN'(out_valid), VLEN'(0));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R9 act=%0d exp<=%0d", cyc, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_known_values();
    for (int c = 1; c < 4; c++) t_specials(2'(c));
    for (int c = 1; c < 4; c++) t_sign(2'(c));
    for (int c = 1; c < 4; c++) t_predicates(2'(c));
    t_illegal();
    t_back_to_back();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule